// File: doc/BRIEF.md
# Completion Bit-Array Update Unit

This block keeps one "done" flag per slot for work items that may finish in any order, and it lets them be retired strictly in slot order. A producer marks a slot complete with a set request that carries the slot index. A consumer issues an update request. The update starts at the retire head, measures the unbroken run of completed slots from that point, clears the run, moves the head past it, and reports the last slot it retired. Each request is a single-cycle read-modify-write inside the block, so several requesters need no lock or polling loop around the flag array.

A completed slot that lies behind an incomplete one stays pending. It is retired only after the gap before it is filled. The head and all slot arithmetic wrap modulo the array depth. When a set and an update arrive in the same cycle, the set takes effect first, so the update may retire the slot that was just marked. A set that targets a slot already marked complete raises a sticky error flag.

Top module: `cbu_commit_unit`

## Requirements
- R1: After reset all flags are clear, the head is slot 0, `upd_valid` and `dup_err` are 0 and `upd_ptr` is DEPTH-1.
- R2: A set request with index i marks slot i complete from the next cycle on.
- R3: An update request retires the unbroken run of completed slots that starts at the head. In the following cycle `upd_valid` is 1 and `upd_count` gives the run length. The retired slots are clear again from then on.
- R4: A completed slot behind an incomplete slot is not retired. It is retired by the first update after the gap is filled.
- R5: When `upd_count` is nonzero, `upd_ptr` is (old head + `upd_count` - 1) mod DEPTH, the last slot retired. The head then advances by `upd_count`.
- R6: When `upd_count` is zero, `upd_ptr` keeps its previous value and no flag changes.
- R7: Runs that cross slot DEPTH-1 continue at slot 0. The head and the pointer wrap modulo DEPTH.
- R8: When a set and an update occur in the same cycle, the set is applied first. A slot marked at the head is retired by that same update.
- R9: A set to a slot that is already complete raises `dup_err`. `dup_err` stays 1 until reset. The duplicate set changes no flag.
- R10: `upd_valid` is 1 exactly in the cycle after each update request and 0 in every other cycle.
- R11: If all DEPTH slots are complete, one update retires all of them. `upd_count` is then DEPTH and the head returns to the same slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_req | input | 1 | Mark slot `set_idx` complete |
| set_idx | input | $clog2(DEPTH) | Slot index for the set request |
| upd_req | input | 1 | Retire the completed run starting at the head |
| upd_valid | output | 1 | Update result present this cycle |
| upd_ptr | output | $clog2(DEPTH) | Last slot retired |
| upd_count | output | $clog2(DEPTH)+1 | Number of slots retired by the update |
| dup_err | output | 1 | Sticky flag: a slot was set twice |

## Verification
The update is exercised under several patterns. An empty array shows that the pointer holds when no slot can retire. A contiguous run at the head checks the run length and the pointer. A run with a hole shows that later slots wait, and filling the hole then releases the whole stretch at once. A run across the top slot separates correct modulo arithmetic from a plain shift. A fully set array probes the largest count and a head that returns to where it started. A set and an update in the same cycle on the head slot shows whether the set is applied before the update. A long pseudo-random mix of sets and updates, compared each cycle against a behavioural model, covers combinations the directed cases miss, including duplicate sets.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int unsigned CBU_DEF_DEPTH = 64;

  typedef enum logic {
    ROT_RIGHT = 1'b0,
    ROT_LEFT  = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/cbu_rotate.sv
module cbu_rotate
  import cbu_pkg::*;
#(
  parameter int unsigned DEPTH = CBU_DEF_DEPTH,
  parameter rot_dir_e    DIR   = ROT_RIGHT,
  localparam int unsigned AMT_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vec_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [DEPTH-1:0] vec_o
);
  logic [2*DEPTH-1:0] dbl;
  logic [2*DEPTH-1:0] shifted;

  assign dbl = {vec_i, vec_i};

  generate
    if (DIR == ROT_RIGHT) begin : g_right
      // slot at amt_i lands in bit 0
      assign shifted = dbl >> amt_i;
      assign vec_o   = shifted[DEPTH-1:0];
    end else begin : g_left
      // bit 0 returns to slot amt_i
      assign shifted = dbl << amt_i;
      assign vec_o   = shifted[2*DEPTH-1:DEPTH];
    end
  endgenerate
endmodule

// File: rtl/cbu_run_len.sv
module cbu_run_len #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [DEPTH-1:0] rot_i,
  output logic [DEPTH-1:0] run_o,
  output logic [CNT_W-1:0] len_o
);
  // prefix AND: run_o[i] set only if bits 0..i are all set
  logic [DEPTH-1:0] pre;

  assign pre[0] = rot_i[0];
  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_pre
      assign pre[i] = pre[i-1] & rot_i[i];
    end
  endgenerate

  assign run_o = pre;

  always_comb begin
    len_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      len_o = len_o + CNT_W'(pre[k]);
    end
  end
endmodule

// File: rtl/cbu_flag_store.sv
module cbu_flag_store #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             upd_req,
  input  logic [DEPTH-1:0] clr_mask_i,
  output logic [DEPTH-1:0] merged_o,
  output logic             dup_err_o
);
  logic [DEPTH-1:0] flags_q, flags_d;
  logic [DEPTH-1:0] set_vec;
  logic             dup_q, dup_d;
  logic             flags_en;

  // next state: set first, then the update's clear
  always_comb begin
    set_vec = '0;
    if (set_req) set_vec[set_idx] = 1'b1;
    merged_o = flags_q | set_vec;
    flags_d  = merged_o & ~clr_mask_i;
    flags_en = set_req | upd_req;
    dup_d    = dup_q | (set_req & flags_q[set_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dup_q <= 1'b0;
    end else if (set_req) begin
      dup_q <= dup_d;
    end
  end

  assign dup_err_o = dup_q;
endmodule

// File: rtl/cbu_commit_unit.sv
module cbu_commit_unit
  import cbu_pkg::*;
#(
  parameter int unsigned DEPTH = CBU_DEF_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             upd_req,
  output logic             upd_valid,
  output logic [IDX_W-1:0] upd_ptr,
  output logic [CNT_W-1:0] upd_count,
  output logic             dup_err
);
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q;

  logic [DEPTH-1:0] merged;
  logic [DEPTH-1:0] rot_view;
  logic [DEPTH-1:0] run_rot;
  logic [DEPTH-1:0] run_abs;
  logic [DEPTH-1:0] clr_mask;
  logic [CNT_W-1:0] run_len;

  cbu_flag_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_req    (set_req),
    .set_idx    (set_idx),
    .upd_req    (upd_req),
    .clr_mask_i (clr_mask),
    .merged_o   (merged),
    .dup_err_o  (dup_err)
  );

  cbu_rotate #(.DEPTH(DEPTH), .DIR(ROT_RIGHT)) u_rot_in (
    .vec_i (merged),
    .amt_i (head_q),
    .vec_o (rot_view)
  );

  cbu_run_len #(.DEPTH(DEPTH)) u_run (
    .rot_i (rot_view),
    .run_o (run_rot),
    .len_o (run_len)
  );

  cbu_rotate #(.DEPTH(DEPTH), .DIR(ROT_LEFT)) u_rot_out (
    .vec_i (run_rot),
    .amt_i (head_q),
    .vec_o (run_abs)
  );

  always_comb begin
    clr_mask = upd_req ? run_abs : '0;
    head_d   = head_q;
    ptr_d    = ptr_q;
    cnt_d    = cnt_q;
    if (upd_req) begin
      cnt_d  = run_len;
      head_d = head_q + run_len[IDX_W-1:0];
      if (run_len != '0) begin
        ptr_d = head_q + run_len[IDX_W-1:0] - IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      ptr_q  <= IDX_W'(DEPTH - 1);
      cnt_q  <= '0;
    end else if (upd_req) begin
      head_q <= head_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd_req;
    end
  end

  assign upd_valid = valid_q;
  assign upd_ptr   = ptr_q;
  assign upd_count = cnt_q;
endmodule

// File: rtl/cbu_commit_unit_chk.sv
module cbu_commit_unit_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_req,
  input logic             upd_valid,
  input logic [IDX_W-1:0] upd_ptr,
  input logic [CNT_W-1:0] upd_count,
  input logic             dup_err
);
  // independent head tracking from reported counts
  logic [IDX_W-1:0] tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (upd_valid) begin
      tail_q <= tail_q + upd_count[IDX_W-1:0];
    end
  end

  assert_valid_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> upd_valid);

  assert_valid_only_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_req |=> !upd_valid);

  assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |=> dup_err);

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_count == '0) |-> $stable(upd_ptr));

  assert_ptr_last_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_count != '0) |-> (upd_ptr == IDX_W'(tail_q + upd_count[IDX_W-1:0] - IDX_W'(1))));

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_count <= CNT_W'(DEPTH)));
endmodule

bind cbu_commit_unit cbu_commit_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_req   (upd_req),
  .upd_valid (upd_valid),
  .upd_ptr   (upd_ptr),
  .upd_count (upd_count),
  .dup_err   (dup_err)
);

// File: tb/cbu_commit_unit_test.sv
`timescale 1ns/1ps
module cbu_commit_unit_test;
  localparam int DEPTH = 64;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic             clk;
  logic             rst_n;
  logic             set_req;
  logic [IDX_W-1:0] set_idx;
  logic             upd_req;
  logic             upd_valid;
  logic [IDX_W-1:0] upd_ptr;
  logic [CNT_W-1:0] upd_count;
  logic             dup_err;

  int checks = 0;
  int fails  = 0;

  // behavioural model
  bit m_flag [DEPTH];
  int m_head, m_ptr, m_cnt;
  bit m_valid, m_dup;

  cbu_commit_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_idx(set_idx),
    .upd_req(upd_req), .upd_valid(upd_valid), .upd_ptr(upd_ptr),
    .upd_count(upd_count), .dup_err(dup_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(upd_valid == m_valid, tag, "upd_valid", int'(upd_valid), int'(m_valid));
    check(dup_err == m_dup, tag, "dup_err", int'(dup_err), int'(m_dup));
    if (m_valid) begin
      check(int'(upd_count) == m_cnt, tag, "upd_count", int'(upd_count), m_cnt);
      check(int'(upd_ptr) == m_ptr, tag, "upd_ptr", int'(upd_ptr), m_ptr);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_flag[i] = 1'b0;
    m_head = 0; m_ptr = DEPTH - 1; m_cnt = 0; m_valid = 1'b0; m_dup = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    set_req = 1'b0; upd_req = 1'b0; set_idx = '0;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive, clock, update model, compare after edge
  task automatic step(input bit s, input int idx, input bit u, input string tag);
    @(negedge clk);
    set_req = s; set_idx = IDX_W'(idx); upd_req = u;
    @(posedge clk);
    if (s) begin
      if (m_flag[idx]) m_dup = 1'b1;
      m_flag[idx] = 1'b1;
    end
    m_valid = u;
    if (u) begin
      m_cnt = 0;
      while (m_cnt < DEPTH && m_flag[(m_head + m_cnt) % DEPTH]) begin
        m_flag[(m_head + m_cnt) % DEPTH] = 1'b0;
        m_cnt++;
      end
      if (m_cnt > 0) m_ptr = (m_head + m_cnt - 1) % DEPTH;
      m_head = (m_head + m_cnt) % DEPTH;
    end
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, 1'b0, tag);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lfsr;
    rst_n = 1'b0; set_req = 1'b0; upd_req = 1'b0; set_idx = '0;
    model_reset();
    do_reset();

    // R1: reset state
    #1;
    check(upd_valid == 1'b0, "R1", "upd_valid", int'(upd_valid), 0);
    check(dup_err == 1'b0, "R1", "dup_err", int'(dup_err), 0);
    check(int'(upd_ptr) == DEPTH - 1, "R1", "upd_ptr", int'(upd_ptr), DEPTH - 1);

    // R6: empty array, no progress
    step(1'b0, 0, 1'b1, "R6");
    idle("R10");

    // R2 R3 R5: contiguous run at head
    step(1'b1, 0, 1'b0, "R2");
    step(1'b1, 1, 1'b0, "R2");
    step(1'b1, 2, 1'b0, "R2");
    step(1'b0, 0, 1'b1, "R3");
    step(1'b0, 0, 1'b1, "R6");

    // R4: gap at slot 3 blocks 4 and 5
    step(1'b1, 5, 1'b0, "R4");
    step(1'b1, 4, 1'b0, "R4");
    step(1'b0, 0, 1'b1, "R4");
    step(1'b1, 3, 1'b0, "R4");
    step(1'b0, 0, 1'b1, "R4");

    // R8: set and update together at head slot 6
    step(1'b1, 6, 1'b1, "R8");
    idle("R10");

    // R9: duplicate set, sticky
    step(1'b1, 10, 1'b0, "R9");
    step(1'b1, 10, 1'b0, "R9");
    idle("R9");
    idle("R9");
    step(1'b0, 0, 1'b1, "R9");

    // R7: wrap across the top slot
    do_reset();
    for (int i = 0; i < 60; i++) step(1'b1, i, 1'b0, "R2");
    step(1'b0, 0, 1'b1, "R5");
    for (int i = 60; i < 64; i++) step(1'b1, i, 1'b0, "R7");
    step(1'b1, 0, 1'b0, "R7");
    step(1'b1, 1, 1'b0, "R7");
    step(1'b0, 0, 1'b1, "R7");

    // R11: full array
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1'b1, (i * 7) % DEPTH, 1'b0, "R2");
    step(1'b0, 0, 1'b1, "R11");
    step(1'b1, 0, 1'b1, "R11");

    // mixed pseudo-random traffic
    do_reset();
    lfsr = 32'h1ACE5;
    for (int n = 0; n < 3000; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      step(lfsr[0], (lfsr >> 4) % DEPTH, (lfsr[9:8] == 2'b00), "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule